// File: doc/BRIEF.md
# Dual-Channel Output Port Router

This block takes the registered samples of two converter channels and places them on two output ports. A select input sets the routing. When select is high, each channel goes to its own port. When select is low, the two channels are exchanged. The block runs at twice the sample rate, and the channel inputs hold each sample for two clocks. If select toggles on every clock, a single port then carries channel A and channel B in turn, at double the sample rate.

Each port has an active-high disable input. A disabled port idles: it drives zeros and drops its valid flag, which is how this block models a bus that is not driven. Each port also carries a tag bit that names the channel it is currently presenting. Multiplexing needs both channels powered. For that reason the block raises an error flag when select changes while either channel's power-down input is high.

Top module: `dual_port_router`

## Requirements
- R1: With select high, port A presents channel A and port B presents channel B one clock after the inputs are sampled. The tag encoding is 0 for channel A and 1 for channel B.
- R2: With select low, port A presents channel B and port B presents channel A one clock later, and the tags follow the same encoding.
- R3: When select toggles on every clock, the data and tag of each port alternate between the two channels on every clock. Port A and port B never present the same channel in the same clock.
- R4: A port whose disable input is high drives zero data, valid 0 and tag 0 one clock later.
- R5: A port whose disable input is low drives valid 1 one clock later.
- R6: The error flag goes high one clock after an edge at which select differs from its value at the previous edge while either power-down input is high. The first edge after reset is never treated as a change.
- R7: The error flag stays low while select is steady, and also when select changes while both power-down inputs are low.
- R8: While reset is asserted, all port data, valid flags, tags and the error flag are 0.
- R9: The power-down inputs have no effect on port data, valid or tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Route select: 1 straight, 0 swapped |
| ch_a_data | input | 10 | Channel A sample |
| ch_b_data | input | 10 | Channel B sample |
| dis_a | input | 1 | Port A disable, active high |
| dis_b | input | 1 | Port B disable, active high |
| pd_a | input | 1 | Channel A power-down |
| pd_b | input | 1 | Channel B power-down |
| port_a_data | output | 10 | Port A data |
| port_b_data | output | 10 | Port B data |
| port_a_valid | output | 1 | Port A carries data |
| port_b_valid | output | 1 | Port B carries data |
| port_a_tag | output | 1 | Channel shown on port A |
| port_b_tag | output | 1 | Channel shown on port B |
| mux_err | output | 1 | Select changed while a channel was powered down |

## Verification
The routing is driven three ways: select held high, select held low, and select toggling on every clock. Each channel carries distinct, changing values, so a port that shows the wrong channel or stale data shows up at once. Holding select steady isolates the straight path from the swapped path. Toggling select exposes a missing or doubled register stage. The error flag is tested by toggling select with each power-down input raised in turn, and again with both low. A separate phase holds select steady while power-down is raised, which tells a true change detector apart from a level check.

// File: rtl/router_pkg.sv
package router_pkg;
   typedef enum logic {
      CH_A = 1'b0,
      CH_B = 1'b1
   } chan_e;
endpackage

// File: rtl/router_lane.sv
module router_lane #(
   parameter int              DATA_W  = 10,
   parameter router_pkg::chan_e OWN_CH = router_pkg::CH_A,
   parameter bit              REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic [DATA_W-1:0] own_d,
   input  logic [DATA_W-1:0] oth_d,
   input  logic              dis,
   output logic [DATA_W-1:0] q_data,
   output logic              q_valid,
   output logic              q_tag
);
   localparam logic OWN_BIT = logic'(OWN_CH);

   logic [DATA_W-1:0] pick_d;
   logic              pick_tag;

   always_comb begin
      pick_d   = sel ? own_d : oth_d;
      pick_tag = sel ? OWN_BIT : ~OWN_BIT;
      if (dis) begin
         pick_d   = '0;
         pick_tag = 1'b0;
      end
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q_data  <= '0;
               q_valid <= 1'b0;
               q_tag   <= 1'b0;
            end else begin
               q_data  <= pick_d;
               q_valid <= ~dis;
               q_tag   <= pick_tag;
            end
         end

         // R1: straight routing shows own channel one clock later
         a_r1_straight: assert property (@(posedge clk) disable iff (!rst_n)
            (sel && !dis) |=> (q_data == $past(own_d) && q_tag == OWN_BIT));
         // R2: swapped routing shows the other channel
         a_r2_swapped: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel && !dis) |=> (q_data == $past(oth_d) && q_tag == ~OWN_BIT));
         // R4: disabled lane idles
         a_r4_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
            dis |=> (q_data == '0 && !q_valid && !q_tag));
         // R5: enabled lane is valid
         a_r5_enabled_valid: assert property (@(posedge clk) disable iff (!rst_n)
            !dis |=> q_valid);
      end else begin : g_comb
         assign q_data  = pick_d;
         assign q_valid = ~dis;
         assign q_tag   = pick_tag;
      end
   endgenerate
endmodule

// File: rtl/mux_guard.sv
module mux_guard (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   input  logic pd_a,
   input  logic pd_b,
   output logic err
);
   logic sel_q;
   logic primed;
   logic changed;

   assign changed = primed & (sel ^ sel_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         primed <= 1'b0;
         err    <= 1'b0;
      end else begin
         sel_q  <= sel;
         primed <= 1'b1;
         err    <= changed & (pd_a | pd_b);
      end
   end

   // R6: an error always has a powered-down channel behind it
   a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(pd_a || pd_b));
   // R7: both channels active never raises the error
   a_r7_no_err_active: assert property (@(posedge clk) disable iff (!rst_n)
      (!pd_a && !pd_b) |=> !err);
endmodule

// File: rtl/dual_port_router.sv
module dual_port_router #(
   parameter int DATA_W  = 10,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic [DATA_W-1:0] ch_a_data,
   input  logic [DATA_W-1:0] ch_b_data,
   input  logic              dis_a,
   input  logic              dis_b,
   input  logic              pd_a,
   input  logic              pd_b,
   output logic [DATA_W-1:0] port_a_data,
   output logic [DATA_W-1:0] port_b_data,
   output logic              port_a_valid,
   output logic              port_b_valid,
   output logic              port_a_tag,
   output logic              port_b_tag,
   output logic              mux_err
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("dual_port_router: DATA_W must be at least 1");
      end
   endgenerate

   router_lane #(.DATA_W(DATA_W), .OWN_CH(router_pkg::CH_A), .REG_OUT(REG_OUT)) u_lane_a (
      .clk(clk), .rst_n(rst_n), .sel(sel),
      .own_d(ch_a_data), .oth_d(ch_b_data), .dis(dis_a),
      .q_data(port_a_data), .q_valid(port_a_valid), .q_tag(port_a_tag));

   router_lane #(.DATA_W(DATA_W), .OWN_CH(router_pkg::CH_B), .REG_OUT(REG_OUT)) u_lane_b (
      .clk(clk), .rst_n(rst_n), .sel(sel),
      .own_d(ch_b_data), .oth_d(ch_a_data), .dis(dis_b),
      .q_data(port_b_data), .q_valid(port_b_valid), .q_tag(port_b_tag));

   mux_guard u_guard (
      .clk(clk), .rst_n(rst_n), .sel(sel),
      .pd_a(pd_a), .pd_b(pd_b), .err(mux_err));

   // R3: two live ports never show the same channel
   a_r3_distinct_tags: assert property (@(posedge clk) disable iff (!rst_n)
      (port_a_valid && port_b_valid) |-> (port_a_tag != port_b_tag));
endmodule

// File: tb/dual_port_router_test.sv
module dual_port_router_test;
   localparam int W = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sel = 1'b1;
   logic [W-1:0] ch_a = '0, ch_b = '0;
   logic         dis_a = 1'b0, dis_b = 1'b0, pd_a = 1'b0, pd_b = 1'b0;
   logic [W-1:0] pa_d, pb_d;
   logic         pa_v, pb_v, pa_t, pb_t, err;

   int tests = 0;
   int fails = 0;
   string req = "R8";
   bit done = 1'b0;

   // reference model state
   int e_pa_d = 0, e_pb_d = 0, e_pa_v = 0, e_pb_v = 0, e_pa_t = 0, e_pb_t = 0, e_err = 0;
   int m_prev_sel = 0, m_primed = 0;

   always #10 clk = ~clk;

   dual_port_router uut (
      .clk(clk), .rst_n(rst_n), .sel(sel),
      .ch_a_data(ch_a), .ch_b_data(ch_b),
      .dis_a(dis_a), .dis_b(dis_b), .pd_a(pd_a), .pd_b(pd_b),
      .port_a_data(pa_d), .port_b_data(pb_d),
      .port_a_valid(pa_v), .port_b_valid(pb_v),
      .port_a_tag(pa_t), .port_b_tag(pb_t), .mux_err(err));

   always @(posedge clk) begin
      if (!rst_n) begin
         e_pa_d = 0; e_pb_d = 0; e_pa_v = 0; e_pb_v = 0;
         e_pa_t = 0; e_pb_t = 0; e_err = 0;
         m_prev_sel = 0; m_primed = 0;
      end else begin
         e_err = (m_primed != 0 && int'(sel) != m_prev_sel && (pd_a || pd_b)) ? 1 : 0;
         m_prev_sel = int'(sel);
         m_primed = 1;
         if (dis_a) begin e_pa_d = 0; e_pa_v = 0; e_pa_t = 0; end
         else begin
            e_pa_v = 1;
            e_pa_d = sel ? int'(ch_a) : int'(ch_b);
            e_pa_t = sel ? 0 : 1;
         end
         if (dis_b) begin e_pb_d = 0; e_pb_v = 0; e_pb_t = 0; end
         else begin
            e_pb_v = 1;
            e_pb_d = sel ? int'(ch_b) : int'(ch_a);
            e_pb_t = sel ? 1 : 0;
         end
      end
   end

   task automatic check(string what, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         check("port_a_data", int'(pa_d), e_pa_d);
         check("port_b_data", int'(pb_d), e_pb_d);
         check("port_a_valid", int'(pa_v), e_pa_v);
         check("port_b_valid", int'(pb_v), e_pb_v);
         check("port_a_tag", int'(pa_t), e_pa_t);
         check("port_b_tag", int'(pb_t), e_pb_t);
         check("mux_err", int'(err), e_err);
      end
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
      end
   endtask

   // new samples every two clocks
   task automatic run(int samples, bit toggle);
      for (int i = 0; i < samples; i++) begin
         ch_a = W'(17 * i + 3);
         ch_b = W'(1000 - 29 * i);
         step(1);
         if (toggle) sel = ~sel;
         step(1);
         if (toggle) sel = ~sel;
      end
   endtask

   initial begin
      req = "R8";
      ch_a = 10'h155; ch_b = 10'h2AA;
      step(3);
      rst_n = 1'b1;
      req = "R1"; sel = 1'b1; run(6, 1'b0);
      req = "R2"; sel = 1'b0; run(6, 1'b0);
      req = "R3"; sel = 1'b1; run(8, 1'b1);
      req = "R4"; dis_a = 1'b1; run(3, 1'b0);
      dis_a = 1'b0; dis_b = 1'b1; sel = 1'b0; run(3, 1'b0);
      req = "R5"; dis_b = 1'b0; run(2, 1'b0);
      req = "R9"; pd_a = 1'b1; pd_b = 1'b1; run(4, 1'b0);
      req = "R6"; pd_b = 1'b0; run(3, 1'b1);
      pd_a = 1'b0; pd_b = 1'b1; run(3, 1'b1);
      req = "R7"; pd_b = 1'b0; run(4, 1'b1);
      pd_a = 1'b1; run(3, 1'b0);
      pd_a = 1'b0;
      req = "R8"; rst_n = 1'b0; step(3);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         tests++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule